// File: doc/BRIEF.md
# Cluster-Aware Candidate Tile Locator

On a tiled multiprocessor whose last-level cache banks can be grouped into clusters of varying size, a block may sit in one of several tiles depending on the current cluster dimension. This locator takes a requesting core number and the block's home tile number. It forms the tile that would hold the block under each cluster dimension. It keeps only the distinct tiles and sends one lookup request per distinct tile. Tiles that cannot hold the block get no request.

Each candidate comes from a masked merge. Bits where the mask is one come from the home tile number, and bits where it is zero come from the core number. The masks start at all ones, which is the fully shared organisation. One bit at a time is cleared, alternating between the upper and lower halves of the tile number (row and column of the mesh), down to all zeros, which is the fully private organisation. A lookup is accepted only while the locator is idle. Requests leave over a valid/ready port, one per cycle at most. Each request carries first and last markers and the number of distinct candidates.

Top module: `tile_cand_locator`

## Requirements
- R1: `in_ready` is 1 whenever no request is pending and 0 from the cycle after a lookup is accepted until its final request handshake; a lookup presented while `in_ready` is 0 is ignored and does not alter the requests in progress.
- R2: For mask M, the candidate tile is (home AND M) OR (core AND NOT M), with bit 0 the least significant bit of the tile number.
- R3: With 4 tile bits the masks are applied in the order 1111, 0111, 0101, 0001, 0000, and requests are issued in that order.
- R4: A tile produced by more than one mask is requested only once, at the position of its first occurrence; every distinct candidate is requested.
- R5: `cand_count` equals the number of distinct candidates (1 to 5 for 16 tiles) and is valid whenever `req_valid` is 1.
- R6: Once `req_valid` is 1, it stays 1 and `req_tile`, `req_first`, `req_last` stay unchanged until a cycle with `req_ready` 1.
- R7: `req_first` is 1 only on the first request of a lookup and `req_last` is 1 only on its final request.
- R8: `done` is 1 for exactly the one cycle after the final request handshake, and `req_valid` is 0 in that cycle.
- R9: After reset, `in_ready` is 1, `req_valid` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Lookup offered |
| in_ready | output | 1 | Locator idle and able to take a lookup |
| in_core | input | TILE_BITS | Requesting core number |
| in_home | input | TILE_BITS | Home tile number of the block |
| req_valid | output | 1 | Request to a candidate tile present |
| req_ready | input | 1 | Request taken by the network |
| req_tile | output | TILE_BITS | Candidate tile of this request |
| req_first | output | 1 | First request of the lookup |
| req_last | output | 1 | Final request of the lookup |
| cand_count | output | $clog2(TILE_BITS+2) | Number of distinct candidates |
| done | output | 1 | One-cycle pulse after the final handshake |

## Verification
The bench builds the locator with its default of four tile bits, which is 16 tiles and five masks. At that size the whole candidate range, from one tile up to five, can be reached with chosen core and home pairs. The bench uses cases where every mask folds onto one tile, cases where the three private-side masks collapse, and cases with five distinct tiles in each bit direction. Back-pressure patterns with stalled and immediate ready, plus lookups offered while busy, test holding and ignoring against a behavioural model with a queue.

// File: rtl/tile_loc_pkg.sv
package tile_loc_pkg;

   // Mask applied at sweep step `step` for a tile number of `nbits` bits.
   // Step 0 is all ones; each later step clears one more bit, alternating
   // between the top of the upper half and the top of the lower half.
   function automatic logic [31:0] sweep_mask(input int nbits, input int step);
      logic [31:0] m;
      int          half;
      int          pos;
      m    = (32'd1 << nbits) - 32'd1;
      half = nbits / 2;
      for (int k = 0; k < 32; k++) begin
         if (k < step) begin
            if ((k % 2) == 0) pos = nbits - 1 - (k / 2);
            else              pos = half - 1 - ((k - 1) / 2);
            m[pos] = 1'b0;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/tile_mask_sweep.sv
module tile_mask_sweep
   import tile_loc_pkg::*;
#(
   parameter int TILE_BITS = 4,
   localparam int NMASK    = TILE_BITS + 1
) (
   input  logic [TILE_BITS-1:0]            core_id,
   input  logic [TILE_BITS-1:0]            home_id,
   output logic [NMASK-1:0][TILE_BITS-1:0] cand
);

   generate
      for (genvar g = 0; g < NMASK; g++) begin : g_step
         localparam logic [31:0]          MFULL = sweep_mask(TILE_BITS, g);
         localparam logic [TILE_BITS-1:0] M     = MFULL[TILE_BITS-1:0];
         assign cand[g] = (home_id & M) | (core_id & ~M);
      end
   endgenerate

endmodule

// File: rtl/tile_dedup.sv
module tile_dedup #(
   parameter int TILE_BITS = 4,
   localparam int NMASK    = TILE_BITS + 1,
   localparam int NTILE    = 1 << TILE_BITS,
   localparam int CW       = $clog2(TILE_BITS + 2)
) (
   input  logic [NMASK-1:0][TILE_BITS-1:0] cand,
   output logic [NMASK-1:0]                keep,
   output logic [CW-1:0]                   count
);

   logic [NMASK:0][NTILE-1:0] seen;

   assign seen[0] = '0;

   generate
      for (genvar g = 0; g < NMASK; g++) begin : g_chain
         assign keep[g]     = ~seen[g][cand[g]];
         assign seen[g + 1] = seen[g] | (NTILE'(1) << cand[g]);
      end
   endgenerate

   always_comb begin
      count = '0;
      for (int i = 0; i < NMASK; i++) count = count + CW'(keep[i]);
   end

endmodule

// File: rtl/tile_cand_locator.sv
module tile_cand_locator #(
   parameter int TILE_BITS = 4,
   localparam int NMASK    = TILE_BITS + 1,
   localparam int CW       = $clog2(TILE_BITS + 2),
   localparam int IW       = $clog2(NMASK)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [TILE_BITS-1:0] in_core,
   input  logic [TILE_BITS-1:0] in_home,
   output logic                 req_valid,
   input  logic                 req_ready,
   output logic [TILE_BITS-1:0] req_tile,
   output logic                 req_first,
   output logic                 req_last,
   output logic [CW-1:0]        cand_count,
   output logic                 done
);

   initial begin
      if (TILE_BITS < 2 || TILE_BITS > 8 || (TILE_BITS % 2) != 0)
         $error("tile_cand_locator: TILE_BITS must be even and in 2..8");
   end

   logic [TILE_BITS-1:0]            core_q, home_q, src_core, src_home;
   logic [NMASK-1:0][TILE_BITS-1:0] cand;
   logic [NMASK-1:0]                keep, pending;
   logic [CW-1:0]                   count_now, count_q;
   logic                            first_q, done_q;
   logic [IW-1:0]                   cur;
   logic                            accept, fire, single;

   assign in_ready = ~|pending;
   assign accept   = in_valid & in_ready;
   assign src_core = in_ready ? in_core : core_q;
   assign src_home = in_ready ? in_home : home_q;

   tile_mask_sweep #(.TILE_BITS(TILE_BITS)) u_sweep (
      .core_id (src_core),
      .home_id (src_home),
      .cand    (cand)
   );

   tile_dedup #(.TILE_BITS(TILE_BITS)) u_dedup (
      .cand  (cand),
      .keep  (keep),
      .count (count_now)
   );

   // lowest pending step is the next request
   always_comb begin
      cur = '0;
      for (int i = NMASK - 1; i >= 0; i--) if (pending[i]) cur = IW'(i);
   end

   assign single     = (pending & (pending - NMASK'(1))) == '0;
   assign req_valid  = |pending;
   assign req_tile   = cand[cur];
   assign req_first  = first_q;
   assign req_last   = req_valid & single;
   assign cand_count = count_q;
   assign done       = done_q;
   assign fire       = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= '0;
         core_q  <= '0;
         home_q  <= '0;
         count_q <= '0;
         first_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= fire & single;
         if (accept) begin
            pending <= keep;
            core_q  <= in_core;
            home_q  <= in_home;
            count_q <= count_now;
            first_q <= 1'b1;
         end else if (fire) begin
            pending[cur] <= 1'b0;
            first_q      <= 1'b0;
         end
      end
   end

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_tile) &&
                                  $stable(req_first) && $stable(req_last));

   assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !in_ready);

   assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_last |=> done && !req_valid);

   assert_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> cand_count >= CW'(1) && cand_count <= CW'(NMASK));

   assert_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_last |=> !req_first);

endmodule

// File: tb/tile_cand_locator_test.sv
module tile_cand_locator_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [3:0] in_core = '0;
   logic [3:0] in_home = '0;
   logic       req_valid;
   logic       req_ready = 1'b0;
   logic [3:0] req_tile;
   logic       req_first, req_last;
   logic [2:0] cand_count;
   logic       done;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   tile_cand_locator #(.TILE_BITS(4)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_core(in_core), .in_home(in_home), .req_valid(req_valid),
      .req_ready(req_ready), .req_tile(req_tile), .req_first(req_first),
      .req_last(req_last), .cand_count(cand_count), .done(done));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void model(input logic [3:0] core, input logic [3:0] home,
                                 ref logic [3:0] q[$]);
      logic [3:0] masks[5] = '{4'hF, 4'h7, 4'h5, 4'h1, 4'h0};
      q.delete();
      foreach (masks[i]) begin
         logic [3:0] t;
         bit dup;
         t = (home & masks[i]) | (core & ~masks[i]);
         dup = 0;
         foreach (q[j]) if (q[j] == t) dup = 1;
         if (!dup) q.push_back(t);
      end
   endfunction

   // stall: bit k of stall_pat holds req_ready low for one cycle before item k
   task automatic lookup(input logic [3:0] core, input logic [3:0] home,
                         input int stall_pat, input bit poke);
      logic [3:0] q[$];
      int n;
      model(core, home, q);
      n = q.size();
      @(negedge clk);
      check("R1 idle ready", in_ready, 1);
      in_valid = 1'b1; in_core = core; in_home = home;
      @(negedge clk);
      if (poke) begin in_core = ~core; in_home = ~home; end
      else in_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         if (stall_pat[k]) begin
            req_ready = 1'b0;
            check("R6 valid held", req_valid, 1);
            check("R6 tile held", req_tile, q[k]);
            @(negedge clk);
         end
         check("R1 busy", in_ready, 0);
         check("R4 valid", req_valid, 1);
         check("R2 R3 R4 tile", req_tile, q[k]);
         check("R7 first", req_first, k == 0);
         check("R7 last", req_last, k == n - 1);
         check("R5 count", cand_count, n);
         check("R8 no early done", done, 0);
         req_ready = 1'b1;
         @(negedge clk);
      end
      in_valid = 1'b0;
      req_ready = 1'b0;
      check("R8 done pulse", done, 1);
      check("R8 valid low", req_valid, 0);
      check("R1 ready again", in_ready, 1);
      @(negedge clk);
      check("R8 done one cycle", done, 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset ready", in_ready, 1);
      check("R9 reset valid", req_valid, 0);
      check("R9 reset done", done, 0);
      rst_n = 1'b1;
      lookup(4'h5, 4'hF, 0, 0);      // F,7,5
      lookup(4'h9, 4'h9, 0, 0);      // single
      lookup(4'h0, 4'hF, 5'b01010, 0);
      lookup(4'hF, 4'h0, 5'b10001, 1);
      lookup(4'h3, 4'hC, 5'b11111, 1);
      lookup(4'hA, 4'h2, 5'b00100, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule